// File: doc/BRIEF.md
# Masked CPU Interrupt Controller

This block gathers interrupt events from up to five sources and presents one level-sensitive request to a 68000-style processor. Each source marks an event with a single-cycle pulse, which sets a pending flag. The flag stays set until software clears it.

The processor sees one register. Reading it returns the pending flags. Writing it does two things in the same cycle: the low bits of the data become the enable mask, and each one in the upper byte clears the matching pending flag. The request is raised only when an enabled source has a pending flag and the processor's priority mask is fully open.

Every source shares one request level and one fixed vector number, which is the first user vector (64). The sources themselves and the processor's acknowledge sequence are outside this block.

Top module: `intc_ctrl`

## Requirements
- R1: After reset, the enable mask and all pending flags are zero, `irq_req` is low and `reg_rdata` is zero.
- R2: A high bit i on `src_pulse` at a clock edge sets pending flag i. The flag is visible on the next read.
- R3: A write with `reg_addr` equal to 0x0E0 loads `reg_wdata[4:0]` into the enable mask. The new mask takes effect on the request from the next cycle.
- R4: In that same write, a one in `reg_wdata[8+i]` clears pending flag i. A zero in that bit leaves the flag as it was.
- R5: If a source pulse and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R6: A read with `reg_addr` equal to 0x0E0 returns the pending flags on `reg_rdata[4:0]` in the same cycle, with bits 15:5 zero. A read at any other address returns zero. Reads never change the pending flags.
- R7: `irq_req` is high exactly when (enable AND pending) is nonzero and `cpu_ipl_mask` equals 0.
- R8: `irq_vector` equals 64 whenever `irq_req` is high, and 0 otherwise.
- R9: A write to any address other than 0x0E0 changes neither the enable mask nor the pending flags.
- R10: A pending flag stays set across any number of idle cycles, so the request holds until the flag is cleared or its enable is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_pulse | input | 5 | One event pulse per source |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 10 | Byte offset within the register block |
| reg_wdata | input | 16 | Write data: enable in 4:0, clear mask in 12:8 |
| reg_rdata | output | 16 | Read data: pending flags in 4:0 |
| cpu_ipl_mask | input | 3 | Processor priority mask |
| irq_req | output | 1 | Interrupt request level |
| irq_vector | output | 8 | Vector number offered with the request |

## Verification
The bench builds the block with its default parameters: five sources, a 16-bit data path, a 10-bit offset, the register at 0x0E0 and vector 64. With these values, every source bit and every clear bit can be reached. Writing 0x1F1F clears all flags and enables all sources at once. A neighbouring offset (0x0E2) exercises the address-miss path. The same-cycle set-and-clear collision on one flag is driven directly, and the priority mask is swept from closed to open while a request is pending.

// File: rtl/intc_pkg.sv
package intc_pkg;

    // Decoded register access for one cycle
    typedef struct packed {
        logic wr_hit;
        logic rd_hit;
    } acc_t;

    localparam int unsigned DEF_SRC_N   = 5;
    localparam int unsigned DEF_IPL_W   = 3;
    localparam int unsigned DEF_VEC_W   = 8;
    localparam int unsigned DEF_VECTOR  = 64;

endpackage

// File: rtl/intc_addr_dec.sv
module intc_addr_dec #(
    parameter int unsigned ADDR_W  = 10,
    parameter int unsigned REG_OFS = 'h0E0
) (
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    output intc_pkg::acc_t    acc
);
    localparam logic [ADDR_W-1:0] OFS = ADDR_W'(REG_OFS);

    always_comb begin
        acc.wr_hit = reg_wr && (reg_addr == OFS);
        acc.rd_hit = reg_rd && (reg_addr == OFS);
    end

endmodule

// File: rtl/intc_pend_bank.sv
module intc_pend_bank #(
    parameter int unsigned SRC_N = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] set_i,
    input  logic [SRC_N-1:0] clr_i,
    output logic [SRC_N-1:0] pend_o
);
    typedef struct packed {
        logic [SRC_N-1:0] pend;
    } st_t;

    st_t st_d, st_q;

    // Per-flag next value: a new event outranks a clear in the same cycle
    for (genvar i = 0; i < SRC_N; i++) begin : g_flag
        always_comb begin
            st_d.pend[i] = set_i[i] | (st_q.pend[i] & ~clr_i[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((st_q.pend & $past(set_i)) == $past(set_i))); // R5
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~set_i) != '0) |=> ((st_q.pend & $past(clr_i & ~set_i)) == '0)); // R4
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i == '0 && clr_i == '0) |=> $stable(st_q.pend)); // R10

endmodule

// File: rtl/intc_req_gen.sv
module intc_req_gen #(
    parameter int unsigned SRC_N  = 5,
    parameter int unsigned IPL_W  = 3,
    parameter int unsigned VEC_W  = 8,
    parameter int unsigned VECTOR = 64
) (
    input  logic [SRC_N-1:0] enable_i,
    input  logic [SRC_N-1:0] pend_i,
    input  logic [IPL_W-1:0] ipl_mask_i,
    output logic             irq_o,
    output logic [VEC_W-1:0] vec_o
);
    localparam logic [VEC_W-1:0] VEC = VEC_W'(VECTOR);

    logic [SRC_N-1:0] live;

    always_comb begin
        live  = enable_i & pend_i;
        irq_o = (enable_i != '0) && (live != '0) && (ipl_mask_i == '0);
        vec_o = irq_o ? VEC : '0;
    end

endmodule

// File: rtl/intc_ctrl.sv
module intc_ctrl #(
    parameter int unsigned SRC_N   = intc_pkg::DEF_SRC_N,
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned ADDR_W  = 10,
    parameter int unsigned REG_OFS = 'h0E0,
    parameter int unsigned CLR_LSB = 8,
    parameter int unsigned IPL_W   = intc_pkg::DEF_IPL_W,
    parameter int unsigned VEC_W   = intc_pkg::DEF_VEC_W,
    parameter int unsigned VECTOR  = intc_pkg::DEF_VECTOR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_N-1:0]  src_pulse,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [IPL_W-1:0]  cpu_ipl_mask,
    output logic              irq_req,
    output logic [VEC_W-1:0]  irq_vector
);
    localparam int unsigned PAD_W = DATA_W - SRC_N;
    localparam logic [VEC_W-1:0] VEC = VEC_W'(VECTOR);

    typedef struct packed {
        logic [SRC_N-1:0] en;
    } ctl_t;

    intc_pkg::acc_t   acc;
    ctl_t             ctl_d, ctl_q;
    logic [SRC_N-1:0] clr;
    logic [SRC_N-1:0] pend;

    intc_addr_dec #(.ADDR_W(ADDR_W), .REG_OFS(REG_OFS)) u_dec (
        .reg_wr   (reg_wr),
        .reg_rd   (reg_rd),
        .reg_addr (reg_addr),
        .acc      (acc)
    );

    always_comb begin
        ctl_d = ctl_q;
        clr   = '0;
        if (acc.wr_hit) begin
            ctl_d.en = reg_wdata[SRC_N-1:0];
            clr      = reg_wdata[CLR_LSB +: SRC_N];
        end
        reg_rdata = acc.rd_hit ? {{PAD_W{1'b0}}, pend} : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    intc_pend_bank #(.SRC_N(SRC_N)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (src_pulse),
        .clr_i  (clr),
        .pend_o (pend)
    );

    intc_req_gen #(.SRC_N(SRC_N), .IPL_W(IPL_W), .VEC_W(VEC_W), .VECTOR(VECTOR)) u_req (
        .enable_i   (ctl_q.en),
        .pend_i     (pend),
        .ipl_mask_i (cpu_ipl_mask),
        .irq_o      (irq_req),
        .vec_o      (irq_vector)
    );

    AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ipl_mask != '0) |-> !irq_req); // R7
    AST_VECTOR_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vector == VEC)); // R8
    AST_MISS_KEEPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !acc.wr_hit |=> $stable(ctl_q.en)); // R9
    AST_READ_PURE: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc.rd_hit) |-> (reg_rdata == '0)); // R6

endmodule

// File: tb/intc_ctrl_tb.sv
module intc_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  src_pulse = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [9:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [2:0]  cpu_ipl_mask = '0;
    logic        irq_req;
    logic [7:0]  irq_vector;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    intc_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cpu_ipl_mask(cpu_ipl_mask),
        .irq_req(irq_req), .irq_vector(irq_vector)
    );

    // Monitor: pops one expected item per read cycle
    always @(negedge clk) begin
        if (reg_rd) begin
            logic [15:0] e;
            string t;
            n_chk++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL %s read with empty scoreboard, got %h expected none", "R6", reg_rdata);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (reg_rdata !== e) begin
                    n_bad++;
                    $display("FAIL %s rdata actual %h expected %h", t, reg_rdata, e);
                end
            end
        end
    end

    task automatic idle_inputs();
        src_pulse = '0; reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0;
    endtask

    task automatic step(input logic [4:0] s, input logic w, input logic [9:0] a,
                        input logic [15:0] d);
        @(posedge clk); #1;
        src_pulse = s; reg_wr = w; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        idle_inputs();
    endtask

    task automatic rd(input logic [9:0] a, input logic [15:0] e, input string t);
        exp_q.push_back(e); tag_q.push_back(t);
        @(posedge clk); #1;
        reg_rd = 1; reg_addr = a;
        @(posedge clk); #1;
        idle_inputs();
    endtask

    task automatic chk_irq(input logic r, input string t);
        logic [7:0] ev;
        @(negedge clk);
        ev = r ? 8'd64 : 8'd0;
        n_chk++;
        if (irq_req !== r || irq_vector !== ev) begin
            n_bad++;
            $display("FAIL %s irq/vec actual %b/%0d expected %b/%0d", t, irq_req, irq_vector, r, ev);
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired, actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        chk_irq(0, "R1");
        #1 rst_n = 1;
        rd(10'h0E0, 16'h0000, "R1");
        // R2: pulses set flags, nothing enabled yet
        step(5'b00101, 0, '0, '0);
        rd(10'h0E0, 16'h0005, "R2");
        rd(10'h0E0, 16'h0005, "R6");
        chk_irq(0, "R7");
        // R3: enable source 0
        step('0, 1, 10'h0E0, 16'h0001);
        chk_irq(1, "R3");
        chk_irq(1, "R8");
        cpu_ipl_mask = 3'd3;
        chk_irq(0, "R7");
        cpu_ipl_mask = 3'd0;
        chk_irq(1, "R7");
        // R9: write at neighbour offset is ignored
        step('0, 1, 10'h0E2, 16'h0500);
        rd(10'h0E0, 16'h0005, "R9");
        chk_irq(1, "R9");
        // R4: clear flag 0, keep enable 0
        step('0, 1, 10'h0E0, 16'h0101);
        rd(10'h0E0, 16'h0004, "R4");
        chk_irq(0, "R4");
        step('0, 1, 10'h0E0, 16'h0004);
        chk_irq(1, "R3");
        step('0, 1, 10'h0E0, 16'h0000);
        chk_irq(0, "R7");
        // R5: set and clear on flag 3 in one cycle
        step(5'b01000, 1, 10'h0E0, 16'h0808);
        rd(10'h0E0, 16'h000C, "R5");
        chk_irq(1, "R5");
        // R10: flags hold while idle
        repeat (20) @(posedge clk);
        rd(10'h0E0, 16'h000C, "R10");
        chk_irq(1, "R10");
        // clear all, enable all
        step('0, 1, 10'h0E0, 16'h1F1F);
        rd(10'h0E0, 16'h0000, "R4");
        chk_irq(0, "R4");
        step(5'b11111, 0, '0, '0);
        rd(10'h0E0, 16'h001F, "R2");
        chk_irq(1, "R7");
        rd(10'h0E2, 16'h0000, "R6");
        rd(10'h0E0, 16'h001F, "R6");
        repeat (2) @(posedge clk);
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL %s scoreboard left %0d items, expected 0", "R6", exp_q.size());
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule